// File: doc/BRIEF.md
# Queue Accumulator Channel with Paced Interrupts

This block is one accumulator channel. It polls either a single queue or a group of up to 32 neighbouring queues, starting from a programmable base number. It sends pop requests one at a time over a simple request/response port. Every non-zero descriptor address that comes back is written into a host list buffer, at the next free slot. When the list holds the programmed number of entries, the channel raises an interrupt. A pacing timer can raise the interrupt earlier, and the host clears the list by acknowledging the interrupt.

The timer counts in microseconds, using a prescaler set by the number of clock cycles per microsecond. One of four pacing policies decides when the timer starts: never, from the last interrupt acknowledge, from the first descriptor stored after an acknowledge, or from the most recent descriptor stored. If the timer expires while the list is empty, no interrupt is raised. While the list is full and not yet acknowledged, no new pop is issued. The configuration inputs are meant to stay constant outside reset.

Top module: `qacc_channel`

## Requirements
- R1: While reset is asserted and just after it, `irq` is 0, `entry_cnt` is 0 and `pop_req` is 0.
- R2: With `cfg_multi`=0, every pop request names `cfg_base_q`, and at most one request is outstanding. `pop_req` and `pop_qid` stay fixed until `pop_ack`. A response with `pop_desc`=0 means the queue is empty, and nothing is stored.
- R3: With `cfg_multi`=1, successive requests go to `cfg_base_q` + offset. The offset steps 0,1,…,31 and then wraps to 0, and starts at 0 after reset.
- R4: Each non-zero response produces one `buf_we` pulse in the cycle of `pop_ack`. Its `buf_idx` equals the current `entry_cnt`, its `buf_data` is the descriptor, and `entry_cnt` then grows by one. Descriptors land in pop order.
- R5: When `entry_cnt` reaches `cfg_entries`, `irq` rises one clock later. No new pop request starts while `entry_cnt` ≥ `cfg_entries`.
- R6: `irq` stays high until `host_ack`. An acknowledge without a store in the same cycle leaves `entry_cnt`=0 and `irq`=0 one clock later.
- R7: If `host_ack` and a store fall in the same cycle, the descriptor goes to index 0 of the fresh list, and `entry_cnt` becomes 1.
- R8: `cfg_mode`=0: the interrupt comes only from the full list. No timer interrupt is raised.
- R9: `cfg_mode`=1: the timer starts at the acknowledge edge. With a non-empty list, `irq` rises `cfg_latency_us`·CLK_PER_US cycles after that edge.
- R10: `cfg_mode`=2: the timer starts at the edge that stores the first descriptor after an acknowledge (or after reset). Later stores do not restart it.
- R11: `cfg_mode`=3: every store restarts the timer. `irq` rises `cfg_latency_us`·CLK_PER_US cycles after the last store edge.
- R12: A timer expiry with an empty list raises no interrupt. In mode 1 the timer re-arms at once, so a later descriptor is reported within one timer period of its store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows polling |
| cfg_multi | input | 1 | 1: poll the 32-queue group; 0: poll the base queue only |
| cfg_base_q | input | QID_W | First queue number of the group |
| cfg_entries | input | CNT_W | List size that triggers the interrupt (1..LIST_MAX) |
| cfg_mode | input | 2 | Pacing policy 0..3 |
| cfg_latency_us | input | LAT_W | Pacing delay in microseconds |
| pop_req | output | 1 | Pop request, held until acknowledged |
| pop_qid | output | QID_W | Queue being popped |
| pop_ack | input | 1 | Pop response valid |
| pop_desc | input | DESC_W | Popped descriptor address, 0 when empty |
| buf_we | output | 1 | Host list write strobe |
| buf_idx | output | IDX_W | Host list slot |
| buf_data | output | DESC_W | Descriptor written to the list |
| irq | output | 1 | Interrupt, held until acknowledged |
| entry_cnt | output | CNT_W | Entries currently in the list |
| host_ack | input | 1 | Host acknowledge: clears list and interrupt |

## Verification
The host acknowledge and a descriptor store can land on the same clock. The bench forces this by raising `host_ack` on the very cycle a write strobe is visible with one entry already in the list. The result is judged by the write slot shown at that moment (index 0) and by an entry count of one after the edge. A second overlap is between timer expiry and a store. Timing sweeps over every timed mode and several latencies compare the interrupt edge against cycle numbers that the bench computes from the acknowledge or store edge.

// File: rtl/qacc_pkg.sv
package qacc_pkg;

   // Pacing policy: selects which event starts the latency timer
   typedef enum logic [1:0] {
      PACE_OFF         = 2'd0,
      PACE_SINCE_IRQ   = 2'd1,
      PACE_SINCE_FIRST = 2'd2,
      PACE_SINCE_LAST  = 2'd3
   } pace_mode_e;

endpackage

// File: rtl/qacc_poller.sv
module qacc_poller #(
   parameter int QID_W    = 14,
   parameter int DESC_W   = 32,
   parameter int GROUP_SZ = 32,
   localparam int OFF_W   = (GROUP_SZ > 1) ? $clog2(GROUP_SZ) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              go,
   input  logic              cfg_multi,
   input  logic [QID_W-1:0]  cfg_base_q,
   input  logic              pop_ack,
   input  logic [DESC_W-1:0] pop_desc,
   output logic              pop_req,
   output logic [QID_W-1:0]  pop_qid,
   output logic              store,
   output logic [DESC_W-1:0] store_desc
);

   logic             req_q;
   logic [QID_W-1:0] qid_q;
   logic [OFF_W-1:0] off_q;
   logic [OFF_W-1:0] off_use;
   logic             resp;

   assign resp = req_q & pop_ack;

   generate
      if (GROUP_SZ == 1) begin : g_one
         assign off_q   = '0;
         assign off_use = '0;
      end else begin : g_group
         logic [OFF_W-1:0] off_nxt;
         always_comb begin
            if (!cfg_multi)
               off_nxt = '0;
            else if (off_q == OFF_W'(GROUP_SZ - 1))
               off_nxt = '0;
            else
               off_nxt = off_q + 1'b1;
         end
         always_ff @(posedge clk) begin
            if (!rst_n)
               off_q <= '0;
            else if (resp)
               off_q <= off_nxt;
         end
         assign off_use = cfg_multi ? off_q : '0;
      end
   endgenerate

   // One request in flight; a new one starts only from the idle state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         qid_q <= '0;
      end else if (!req_q) begin
         if (enable && go) begin
            req_q <= 1'b1;
            qid_q <= cfg_base_q + QID_W'(off_use);
         end
      end else if (pop_ack) begin
         req_q <= 1'b0;
      end
   end

   assign pop_req    = req_q;
   assign pop_qid    = qid_q;
   assign store      = resp & (pop_desc != '0);
   assign store_desc = pop_desc;

endmodule

// File: rtl/qacc_list.sv
module qacc_list #(
   parameter int DESC_W   = 32,
   parameter int LIST_MAX = 64,
   localparam int CNT_W   = $clog2(LIST_MAX + 1),
   localparam int IDX_W   = $clog2(LIST_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store,
   input  logic [DESC_W-1:0] store_desc,
   input  logic              host_ack,
   input  logic [CNT_W-1:0]  cfg_entries,
   output logic              buf_we,
   output logic [IDX_W-1:0]  buf_idx,
   output logic [DESC_W-1:0] buf_data,
   output logic [CNT_W-1:0]  cnt,
   output logic              full
);

   logic [CNT_W-1:0] cnt_q;

   // An acknowledge opens a fresh list; a store in the same cycle lands in slot 0
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (host_ack)
         cnt_q <= CNT_W'(store);
      else if (store)
         cnt_q <= cnt_q + 1'b1;
   end

   assign buf_we   = store;
   assign buf_idx  = host_ack ? '0 : cnt_q[IDX_W-1:0];
   assign buf_data = store_desc;
   assign cnt      = cnt_q;
   assign full     = (cnt_q >= cfg_entries);

endmodule

// File: rtl/qacc_pace_timer.sv
module qacc_pace_timer #(
   parameter int CLK_PER_US = 50,
   parameter int LAT_W      = 16,
   localparam int PRE_W     = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [LAT_W-1:0] latency,
   output logic             armed,
   output logic             expire
);

   logic             armed_q;
   logic [LAT_W-1:0] lat_q;
   logic [LAT_W-1:0] lat_lim;
   logic             tick;

   assign lat_lim = (latency == '0) ? '0 : latency - 1'b1;

   generate
      if (CLK_PER_US == 1) begin : g_no_pre
         assign tick = armed_q;
      end else begin : g_pre
         logic [PRE_W-1:0] pre_q;
         assign tick = armed_q && (pre_q == PRE_W'(CLK_PER_US - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || start || tick)
               pre_q <= '0;
            else if (armed_q)
               pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate

   assign expire = tick && (lat_q == lat_lim);

   // One-shot: start wins, expiry or stop disarms
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         lat_q   <= '0;
      end else if (start) begin
         armed_q <= 1'b1;
         lat_q   <= '0;
      end else if (stop || expire) begin
         armed_q <= 1'b0;
      end else if (tick) begin
         lat_q <= lat_q + 1'b1;
      end
   end

   assign armed = armed_q;

endmodule

// File: rtl/qacc_channel.sv
module qacc_channel
   import qacc_pkg::*;
#(
   parameter int QID_W      = 14,
   parameter int DESC_W     = 32,
   parameter int GROUP_SZ   = 32,
   parameter int LIST_MAX   = 64,
   parameter int CLK_PER_US = 50,
   parameter int LAT_W      = 16,
   localparam int CNT_W     = $clog2(LIST_MAX + 1),
   localparam int IDX_W     = $clog2(LIST_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              cfg_multi,
   input  logic [QID_W-1:0]  cfg_base_q,
   input  logic [CNT_W-1:0]  cfg_entries,
   input  logic [1:0]        cfg_mode,
   input  logic [LAT_W-1:0]  cfg_latency_us,
   output logic              pop_req,
   output logic [QID_W-1:0]  pop_qid,
   input  logic              pop_ack,
   input  logic [DESC_W-1:0] pop_desc,
   output logic              buf_we,
   output logic [IDX_W-1:0]  buf_idx,
   output logic [DESC_W-1:0] buf_data,
   output logic              irq,
   output logic [CNT_W-1:0]  entry_cnt,
   input  logic              host_ack
);

   generate
      if (GROUP_SZ < 1 || GROUP_SZ > 32) begin : g_bad_group
         $error("GROUP_SZ must be 1..32");
      end
      if (LIST_MAX < 2) begin : g_bad_list
         $error("LIST_MAX must be at least 2");
      end
      if (CLK_PER_US < 1) begin : g_bad_clk
         $error("CLK_PER_US must be at least 1");
      end
      if (QID_W < $clog2(GROUP_SZ + 1)) begin : g_bad_qid
         $error("QID_W too narrow for the queue group");
      end
      if (DESC_W < 1 || LAT_W < 1) begin : g_bad_width
         $error("DESC_W and LAT_W must be positive");
      end
   endgenerate

   pace_mode_e        mode;
   logic              store;
   logic [DESC_W-1:0] store_desc;
   logic              full;
   logic              t_armed;
   logic              t_expire;
   logic              t_start;
   logic              t_stop;
   logic              start_raw;
   logic              fire;
   logic              irq_q;
   logic              list_nz;

   assign mode    = pace_mode_e'(cfg_mode);
   assign list_nz = (entry_cnt != '0);

   qacc_poller #(
      .QID_W    (QID_W),
      .DESC_W   (DESC_W),
      .GROUP_SZ (GROUP_SZ)
   ) u_poller (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .go         (!full),
      .cfg_multi  (cfg_multi),
      .cfg_base_q (cfg_base_q),
      .pop_ack    (pop_ack),
      .pop_desc   (pop_desc),
      .pop_req    (pop_req),
      .pop_qid    (pop_qid),
      .store      (store),
      .store_desc (store_desc)
   );

   qacc_list #(
      .DESC_W   (DESC_W),
      .LIST_MAX (LIST_MAX)
   ) u_list (
      .clk         (clk),
      .rst_n       (rst_n),
      .store       (store),
      .store_desc  (store_desc),
      .host_ack    (host_ack),
      .cfg_entries (cfg_entries),
      .buf_we      (buf_we),
      .buf_idx     (buf_idx),
      .buf_data    (buf_data),
      .cnt         (entry_cnt),
      .full        (full)
   );

   qacc_pace_timer #(
      .CLK_PER_US (CLK_PER_US),
      .LAT_W      (LAT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (t_start),
      .stop    (t_stop),
      .latency (cfg_latency_us),
      .armed   (t_armed),
      .expire  (t_expire)
   );

   // Interrupt raise: full list, or timer expiry with something to report
   assign fire = !irq_q && !host_ack && (full || (t_expire && list_nz));

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else if (host_ack)
         irq_q <= 1'b0;
      else if (fire)
         irq_q <= 1'b1;
   end

   // Timer start policy per pacing mode
   always_comb begin
      unique case (mode)
         PACE_OFF:         start_raw = 1'b0;
         PACE_SINCE_IRQ:   start_raw = host_ack || !t_armed || (t_expire && !list_nz);
         PACE_SINCE_FIRST: start_raw = store && (!t_armed || t_expire || host_ack);
         PACE_SINCE_LAST:  start_raw = store;
         default:          start_raw = 1'b0;
      endcase
   end

   assign t_start = start_raw && !fire && (host_ack || !irq_q);
   assign t_stop  = fire || (mode == PACE_OFF) ||
                    (host_ack && (mode == PACE_SINCE_FIRST || mode == PACE_SINCE_LAST));

   assign irq = irq_q;

endmodule

// File: rtl/qacc_chk.sv
module qacc_chk #(
   parameter int QID_W    = 14,
   parameter int GROUP_SZ = 32,
   parameter int LIST_MAX = 64,
   localparam int CNT_W   = $clog2(LIST_MAX + 1),
   localparam int IDX_W   = $clog2(LIST_MAX)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_multi,
   input logic [QID_W-1:0] cfg_base_q,
   input logic [CNT_W-1:0] cfg_entries,
   input logic [1:0]       cfg_mode,
   input logic             pop_req,
   input logic [QID_W-1:0] pop_qid,
   input logic             pop_ack,
   input logic             buf_we,
   input logic [IDX_W-1:0] buf_idx,
   input logic             irq,
   input logic [CNT_W-1:0] entry_cnt,
   input logic             host_ack
);

   a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !pop_ack) |=> (pop_req && $stable(pop_qid)));

   a_r2_single_queue: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !cfg_multi) |-> (pop_qid == cfg_base_q));

   a_r3_in_group: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req |-> (QID_W'(pop_qid - cfg_base_q) < GROUP_SZ));

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (CNT_W'(buf_idx) < cfg_entries));

   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && !host_ack) |=> (entry_cnt == $past(entry_cnt) + 1'b1));

   a_r5_full_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ((entry_cnt >= cfg_entries) && !host_ack) |=> irq);

   a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
      ((entry_cnt >= cfg_entries) && !pop_req) |=> !pop_req);

   a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !host_ack) |=> irq);

   a_r6_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ack && !buf_we) |=> ((entry_cnt == '0) && !irq));

   a_r7_merge: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ack && buf_we) |=> (entry_cnt == CNT_W'(1)));

   a_r8_mode0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_mode == 2'd0) && !irq && !host_ack && (entry_cnt < cfg_entries)) |=> !irq);

endmodule

bind qacc_channel qacc_chk #(
   .QID_W    (QID_W),
   .GROUP_SZ (GROUP_SZ),
   .LIST_MAX (LIST_MAX)
) u_chk (.*);

// File: tb/tb_qacc_channel.sv
module tb_qacc_channel;

   localparam int QID_W  = 8;
   localparam int DESC_W = 32;
   localparam int GROUP  = 32;
   localparam int LMAX   = 8;
   localparam int P      = 4;
   localparam int LAT_W  = 8;
   localparam int CNT_W  = $clog2(LMAX + 1);
   localparam int IDX_W  = $clog2(LMAX);

   logic              clk;
   logic              rst_n;
   logic              enable;
   logic              cfg_multi;
   logic [QID_W-1:0]  cfg_base_q;
   logic [CNT_W-1:0]  cfg_entries;
   logic [1:0]        cfg_mode;
   logic [LAT_W-1:0]  cfg_latency_us;
   logic              pop_req;
   logic [QID_W-1:0]  pop_qid;
   logic              pop_ack;
   logic [DESC_W-1:0] pop_desc;
   logic              buf_we;
   logic [IDX_W-1:0]  buf_idx;
   logic [DESC_W-1:0] buf_data;
   logic              irq;
   logic [CNT_W-1:0]  entry_cnt;
   logic              host_ack;

   qacc_channel #(
      .QID_W (QID_W), .DESC_W (DESC_W), .GROUP_SZ (GROUP),
      .LIST_MAX (LMAX), .CLK_PER_US (P), .LAT_W (LAT_W)
   ) dut (.*);

   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   int qcnt [256];
   int qseq [256];
   int exp_q, rr_bad, base_i;
   logic [DESC_W-1:0] mem [LMAX];
   int n_cap, c_first, c_last;

   initial begin
      clk = 0;
      forever #10 clk = ~clk;
   end

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DESC_W-1:0] mk_desc(int q, int s);
      return {8'hC0, q[7:0], 8'h5A, s[7:0]};
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   // Queue model answering pop requests two time units after an edge
   initial begin
      pop_ack = 0;
      pop_desc = '0;
      forever begin
         @(posedge clk);
         #2;
         if (pop_ack) begin
            pop_ack = 0;
            pop_desc = '0;
         end else if (pop_req) begin
            int q;
            q = int'(pop_qid);
            if (q != exp_q) rr_bad++;
            exp_q = cfg_multi ? base_i + ((q - base_i + 1) % GROUP) : base_i;
            if (qcnt[q] > 0) begin
               pop_desc = mk_desc(q, qseq[q]);
               qseq[q]++;
               qcnt[q]--;
            end else begin
               pop_desc = '0;
            end
            pop_ack = 1;
         end
      end
   end

   // Host list model
   initial begin
      forever begin
         @(negedge clk);
         if (buf_we) begin
            mem[buf_idx] = buf_data;
            if (n_cap == 0) c_first = cyc;
            c_last = cyc;
            n_cap++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   task automatic do_reset(input bit multi, input int base, input int ent,
                           input int mode, input int lat);
      rst_n = 0;
      host_ack = 0;
      enable = 1;
      cfg_multi = multi;
      cfg_base_q = QID_W'(base);
      cfg_entries = CNT_W'(ent);
      cfg_mode = 2'(mode);
      cfg_latency_us = LAT_W'(lat);
      for (int q = 0; q < 256; q++) begin
         qcnt[q] = 0;
         qseq[q] = 0;
      end
      base_i = base;
      exp_q = base;
      rr_bad = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      n_cap = 0;
   endtask

   task automatic wait_irq(input int lim, output int t);
      t = -1;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (irq) begin
            t = cyc;
            break;
         end
      end
   endtask

   task automatic ack_pulse();
      host_ack = 1;
      @(negedge clk);
      host_ack = 0;
   endtask

   initial begin
      int t, c0, seen;
      n_cap = 0;
      do_reset(0, 5, 4, 0, 1);
      rst_n = 0;
      @(negedge clk);
      // R1 reset state
      chk(irq == 0 && entry_cnt == 0 && pop_req == 0, "R1 reset", int'(irq), 0);
      rst_n = 1;
      @(negedge clk);
      chk(irq == 0 && entry_cnt == 0, "R1 after release", int'(entry_cnt), 0);

      // Sweep every list size in mode 0, single queue
      for (int e = 1; e <= LMAX; e++) begin
         do_reset(0, 5, e, 0, 1);
         qcnt[5] = 10;
         wait_irq(400, t);
         chk(t == c_last + 2, "R5 full irq timing", t, c_last + 2);
         chk(int'(entry_cnt) == e, "R5 count at full", int'(entry_cnt), e);
         chk(n_cap == e, "R4 stores", n_cap, e);
         for (int i = 0; i < e; i++)
            chk(mem[i] == mk_desc(5, i), "R4 order", int'(mem[i][7:0]), i);
         seen = 0;
         repeat (20) begin
            @(negedge clk);
            if (pop_req) seen = 1;
            if (!irq) seen = 2;
         end
         chk(seen == 0, "R5 stall / R6 hold", seen, 0);
         ack_pulse();
         chk(irq == 0 && entry_cnt == 0, "R6 ack clears", int'(entry_cnt), 0);
         chk(rr_bad == 0, "R2 single queue", rr_bad, 0);
      end

      // R7: acknowledge on the same cycle as a store
      do_reset(0, 5, 4, 0, 1);
      qcnt[5] = 2;
      seen = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (buf_we && entry_cnt == 1) begin
            seen = 1;
            break;
         end
      end
      chk(seen == 1, "R7 overlap reached", seen, 1);
      host_ack = 1;
      #1;
      chk(buf_idx == 0, "R7 slot", int'(buf_idx), 0);
      @(negedge clk);
      host_ack = 0;
      chk(entry_cnt == 1 && irq == 0, "R7 count", int'(entry_cnt), 1);

      // R3: multi-queue round robin with wrap
      do_reset(1, 40, 3, 0, 1);
      qcnt[40] = 1; qcnt[43] = 1; qcnt[71] = 1;
      wait_irq(400, t);
      chk(t != -1, "R3 irq", t, 0);
      chk(mem[0] == mk_desc(40, 0), "R3 first", int'(mem[0][15:8]), 40);
      chk(mem[1] == mk_desc(43, 0), "R3 second", int'(mem[1][15:8]), 43);
      chk(mem[2] == mk_desc(71, 0), "R3 third", int'(mem[2][15:8]), 71);
      qcnt[40] = 1; qcnt[41] = 1;
      n_cap = 0;
      ack_pulse();
      repeat (80) @(negedge clk);
      chk(n_cap == 2, "R3 wrap stores", n_cap, 2);
      chk(mem[0] == mk_desc(40, 1), "R3 wrap first", int'(mem[0][7:0]), 1);
      chk(mem[1] == mk_desc(41, 0), "R3 wrap second", int'(mem[1][15:8]), 41);
      chk(rr_bad == 0, "R3 sequence", rr_bad, 0);

      // R8: mode 0 never times out
      do_reset(0, 5, 8, 0, 1);
      qcnt[5] = 3;
      repeat (200) @(negedge clk);
      chk(irq == 0 && entry_cnt == 3, "R8 no timer irq", int'(irq), 0);

      // Timed modes, latency sweep
      for (int m = 1; m <= 3; m++) begin
         for (int lat = 1; lat <= 3; lat++) begin
            string rq;
            int exp_t, npush;
            rq = (m == 1) ? "R9" : (m == 2) ? "R10" : "R11";
            do_reset(0, 5, 8, m, lat);
            repeat (10) @(negedge clk);
            if (m == 1) begin
               repeat (40) @(negedge clk);
               chk(irq == 0, "R12 empty expiry", int'(irq), 0);
               n_cap = 0;
               qcnt[5] = 1;
               wait_irq(100, t);
               chk(t != -1 && t <= c_first + 1 + lat * P, "R12 rearm", t, c_first + 1 + lat * P);
               qcnt[5] = 1;
               host_ack = 1;
               c0 = cyc;
               @(negedge clk);
               host_ack = 0;
               exp_t = c0 + 1 + lat * P;
               npush = 1;
               wait_irq(100, t);
            end else begin
               n_cap = 0;
               qcnt[5] = 2;
               npush = 2;
               wait_irq(100, t);
               exp_t = ((m == 2) ? c_first : c_last) + 1 + lat * P;
            end
            chk(t == exp_t, rq, t, exp_t);
            chk(int'(entry_cnt) == npush, rq, int'(entry_cnt), npush);
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule